// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. The controller gives it a starting column, a three-bit length code, a type bit that picks sequential or interleaved ordering, and a one-cycle start strobe. Starting on the clock edge that accepts the strobe, the sequencer outputs one column per cycle. Each column comes with a valid flag, and a final-beat flag marks the closing column of a burst that has a fixed length.

Bursts of 2, 4 and 8 beats stay inside an aligned group of columns of that size. Sequential ordering counts upward and wraps back to the start of the group. Interleaved ordering XORs the beat number into the low column bits. A whole-row burst counts through every column of the row, wrapping from the top back to column zero, and continues until the controller raises the stop input. The stop input can also cut any shorter burst early.

A new start is accepted on the final beat of a burst, so bursts can run back to back without an idle cycle.

Top module: `burst_col_seq`

## Requirements
- R1: With length code 0 (one beat), exactly one beat is issued. It carries the start column with the final-beat flag set, and the type bit has no effect on it.
- R2: For length codes 1, 2 and 3 (2, 4 and 8 beats), every beat keeps the column bits above the low 1, 2 or 3 bits equal to those of the start column.
- R3: In sequential ordering (type bit 0), beat i has low bits equal to (start offset + i) modulo the burst length. For example, start 2 with 4 beats gives 2,3,0,1.
- R4: In interleaved ordering (type bit 1), beat i has low bits equal to start offset XOR i. For example, start 1 with 4 beats gives 1,0,3,2, and start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R5: Length code 7 (whole row) issues the start column plus i modulo 2^COL_W (512 columns by default) on beat i. It never raises the final-beat flag, and it uses sequential ordering even when the type bit is 1.
- R6: If stop is high in a cycle where a beat is shown, no further beat of that burst is issued.
- R7: A start is accepted only when no beat is shown or when the final beat is shown. A start during any other beat is ignored. A start accepted on the final beat produces its first beat in the very next cycle.
- R8: Length codes 4, 5 and 6 are reserved. An accepted start carrying one of them issues no beats and raises the error flag for exactly one cycle.
- R9: The final-beat flag is high only together with the valid flag, and only on the last beat of a burst of 1, 2, 4 or 8 beats.
- R10: After reset, the valid, final-beat and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a burst |
| col_i | input | COL_W | Starting column of the burst |
| blen_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 7=whole row, others reserved |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Ends the running burst after the beat currently shown |
| col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is shown on col_o |
| last_o | output | 1 | The beat shown is the final one |
| err_o | output | 1 | One-cycle pulse after a start with a reserved code |

## Verification
The checker covers these rules on every cycle:
- the final-beat flag and the error flag never appear together with the wrong valid state;
- the sequencer stays idle when no start arrives;
- stop ends the burst on the following cycle;
- a single-beat start yields its column one cycle later;
- a reserved code produces the error pulse with no beat.

Only the bench scenarios can confirm the exact beat orderings (sequential and interleaved wrap, and the whole-row wrap at the top of the row). The same holds for the rejection of a start issued mid-burst and for gap-free chaining of bursts, because those depend on complete beat sequences compared against a scoreboard.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [2:0] {
        BL_ONE  = 3'd0,
        BL_TWO  = 3'd1,
        BL_FOUR = 3'd2,
        BL_EIGHT = 3'd3,
        BL_ROW  = 3'd7
    } blen_e;

    function automatic logic code_reserved(input logic [2:0] code);
        return (code == 3'd4) || (code == 3'd5) || (code == 3'd6);
    endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code_i,
    output logic [COL_W-1:0] wrap_mask_o,
    output logic             row_o,
    output logic             bad_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    always_comb begin
        wrap_mask_o = '0;
        row_o       = 1'b0;
        bad_o       = code_reserved(code_i);
        case (code_i)
            BL_TWO:   wrap_mask_o = (ONE << 1) - ONE;
            BL_FOUR:  wrap_mask_o = (ONE << 2) - ONE;
            BL_EIGHT: wrap_mask_o = (ONE << 3) - ONE;
            BL_ROW: begin
                wrap_mask_o = '1;
                row_o       = 1'b1;
            end
            default:  wrap_mask_o = '0;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] wrap_mask_i,
    input  logic             xor_mode_i,
    input  logic [COL_W-1:0] beat_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_sum;
    logic [COL_W-1:0] low_xor;
    logic [COL_W-1:0] low_pick;

    always_comb begin
        low_sum  = base_i + beat_i;
        low_xor  = base_i ^ beat_i;
        low_pick = xor_mode_i ? low_xor : low_sum;
        col_o    = (base_i & ~wrap_mask_i) | (low_pick & wrap_mask_i);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       blen_i,
    input  logic             interleave_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             last_o,
    output logic             err_o
);
    localparam logic [COL_W-1:0] STEP = COL_W'(1);

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             err;
        logic             row;
        logic             xmode;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] col;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [COL_W-1:0] new_mask;
    logic             new_row;
    logic             new_bad;
    logic [COL_W-1:0] beat_nx;
    logic [COL_W-1:0] col_nx;
    logic             take;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i      (blen_i),
        .wrap_mask_o (new_mask),
        .row_o       (new_row),
        .bad_o       (new_bad)
    );

    assign beat_nx = st_q.beat + STEP;

    burst_addr_gen #(.COL_W(COL_W)) u_gen (
        .base_i      (st_q.base),
        .wrap_mask_i (st_q.mask),
        .xor_mode_i  (st_q.xmode),
        .beat_i      (beat_nx),
        .col_o       (col_nx)
    );

    assign take = start_i && (!st_q.valid || st_q.last);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (take) begin
            if (new_bad) begin
                st_d.valid = 1'b0;
                st_d.last  = 1'b0;
                st_d.err   = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.row   = new_row;
                st_d.xmode = interleave_i && !new_row;
                st_d.base  = col_i;
                st_d.mask  = new_mask;
                st_d.beat  = '0;
                st_d.col   = col_i;
                st_d.last  = !new_row && (new_mask == '0);
            end
        end else if (st_q.valid) begin
            if (stop_i || st_q.last) begin
                st_d.valid = 1'b0;
                st_d.last  = 1'b0;
            end else begin
                st_d.beat = beat_nx;
                st_d.col  = col_nx;
                st_d.last = !st_q.row && (beat_nx == st_q.mask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o        = st_q.col;
    assign beat_valid_o = st_q.valid;
    assign last_o       = st_q.last;
    assign err_o        = st_q.err;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic [2:0]       blen_i,
    input logic             interleave_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_valid_o,
    input logic             last_o,
    input logic             err_o
);
    logic can_take;
    assign can_take = start_i && (!beat_valid_o || last_o);

    // R9
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_valid_o);

    // R8
    err_without_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !beat_valid_o);

    // R8
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (can_take && (blen_i == 3'd4 || blen_i == 3'd5 || blen_i == 3'd6))
        |=> (err_o && !beat_valid_o));

    // R6
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && stop_i && !start_i) |=> !beat_valid_o);

    // R7
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid_o && !start_i) |=> (!beat_valid_o && !err_o));

    // R1
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (can_take && blen_i == 3'd0) |=> (beat_valid_o && last_o && col_o == $past(col_i)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!beat_valid_o && !last_o && !err_o));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int COL_W = 9;
    localparam int ROW   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [2:0]       blen_i = '0;
    logic             interleave_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_valid_o;
    logic             last_o;
    logic             err_o;

    int checks = 0;
    int errors = 0;
    int q_col[$];
    bit q_last[$];
    string q_tag[$];

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int blen_beats(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            default: return ROW;
        endcase
    endfunction

    function automatic int model_col(input int col, input int code, input bit il, input int i);
        int n, grp, off;
        n = blen_beats(code);
        if (n == ROW) return (col + i) % ROW;
        grp = col - (col % n);
        off = col % n;
        if (il) return grp + (off ^ i);
        return grp + ((off + i) % n);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && beat_valid_o) begin
            if (q_col.size() == 0) begin
                chk(1'b0, "R6/R7 unexpected beat", int'(col_o), -1);
            end else begin
                int ec; bit el; string et;
                ec = q_col.pop_front();
                el = q_last.pop_front();
                et = q_tag.pop_front();
                chk(int'(col_o) == ec, {et, " column"}, int'(col_o), ec);
                chk(last_o == el, {"R9 last flag ", et}, int'(last_o), int'(el));
            end
        end
    end

    // keep: beats before stop (0 = run to end); poke: beat step with a stray start
    task automatic burst(input int col, input int code, input bit il,
                         input int keep, input int poke, input string tag);
        int total, k;
        bit row;
        total = blen_beats(code);
        row   = (total == ROW);
        k     = (keep > 0) ? keep : total;
        for (int i = 0; i < k; i++) begin
            q_col.push_back(model_col(col, code, il, i));
            q_last.push_back((i == total - 1) && !row);
            q_tag.push_back(tag);
        end
        col_i = COL_W'(col); blen_i = 3'(code); interleave_i = il; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(beat_valid_o, "R7 first beat follows accepted start", int'(beat_valid_o), 1);
        for (int j = 1; j < k; j++) begin
            if (j == poke) begin
                start_i = 1'b1; col_i = COL_W'(col ^ 9'h1F0); blen_i = 3'd3;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        if (keep > 0) begin
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
            chk(!beat_valid_o, "R6 idle after stop", int'(beat_valid_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10
        chk(!beat_valid_o && !last_o && !err_o, "R10 reset outputs", int'({beat_valid_o, last_o, err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        burst(37, 0, 1'b0, 0, 0, "R1 single seq"); @(negedge clk);
        burst(38, 0, 1'b1, 0, 0, "R1 single type ignored"); @(negedge clk);
        burst(2, 2, 1'b0, 0, 0, "R3 start2 len4"); @(negedge clk);
        burst(101, 1, 1'b0, 0, 0, "R2 R3 len2"); @(negedge clk);
        burst(301, 2, 1'b1, 0, 0, "R4 start1 len4");
        burst(205, 3, 1'b1, 0, 0, "R4 start5 len8");
        burst(94, 3, 1'b0, 0, 0, "R2 R3 len8 back-to-back");
        burst(3, 1, 1'b1, 0, 0, "R4 len2 back-to-back"); @(negedge clk);
        burst(509, 7, 1'b0, 6, 0, "R5 row wrap"); @(negedge clk);
        burst(255, 7, 1'b1, 4, 0, "R5 row ignores interleave"); @(negedge clk);
        burst(16, 3, 1'b0, 3, 0, "R6 early stop"); @(negedge clk);
        burst(42, 3, 1'b0, 0, 3, "R7 stray start ignored"); @(negedge clk);
        burst(13, 2, 1'b1, 0, 2, "R7 stray start interleaved"); @(negedge clk);

        // R8 reserved codes
        for (int c = 4; c < 7; c++) begin
            col_i = 9'd77; blen_i = 3'(c); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(err_o && !beat_valid_o, "R8 reserved code flags error", int'({err_o, beat_valid_o}), 2);
            @(negedge clk);
            chk(!err_o && !beat_valid_o, "R8 error one cycle", int'({err_o, beat_valid_o}), 0);
        end

        repeat (4) @(negedge clk);
        chk(q_col.size() == 0, "R6 R7 all expected beats seen", q_col.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R7 run did not end actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule